// File: doc/BRIEF.md
# Serial Converter Sampling Master

This block drives a three-wire read-only serial link to a successive-approximation converter that pads its 12-bit result to a 16-bit frame. It owns the chip-select and the serial clock. The clock rests high between frames, and its rate is set by a programmable divider of the system clock. The block shifts in one 16-bit word per frame. It then right-aligns the 12-bit conversion result, using a shift whose amount depends on the selected clock phase, and hands the result to the core with a single-cycle valid strobe.

A frame request is a one-cycle start pulse. Each request runs a programmable number of back-to-back frames, and the chip-select is held high for at least one serial clock period between frames. In phase 0 the block raises and lowers the chip-select itself. In phase 1 the chip-select pin mirrors a separate manual control input. A power-down request runs a single 8-clock dummy frame. Chip-select therefore rises well before the converter's tenth falling clock edge, and no result is reported for that frame.

Top module: `adc_spi_sampler`

## Requirements
- R1: While reset is held, cs_n is 1, sclk is 1, busy is 0 and sample_valid is 0.
- R2: sclk rests at 1 whenever no frame is active, and each sclk half-period inside a frame lasts exactly half_div system clocks, with a half_div of 0 acting as 1. A half_div of 4 on a 50 MHz system clock gives 6.25 MHz.
- R3: A normal frame produces exactly 16 falling and 16 rising sclk edges, with the first edge a falling edge.
- R4: With cpha = 0, miso is captured at each falling sclk edge, MSB first, and sample equals bits [13:2] of the 16-bit word (the word shifted right by 2).
- R5: With cpha = 1, miso is captured at each rising sclk edge, MSB first, and sample equals bits [14:3] of the 16-bit word (the word shifted right by 3).
- R6: With cpha = 0, cs_n is driven low by the block for each frame and high otherwise. With cpha = 1, cs_n equals cs_man_n at all times.
- R7: Each normal frame ends with sample_valid high for exactly one cycle, and sample holds its value until the next result.
- R8: A start with pd_req = 1 runs one frame of 8 falling and 8 rising edges, releases cs_n before any ninth falling edge, and produces no sample_valid pulse.
- R9: Between consecutive frames of one request, cs_n stays high for at least 2 × half_div system clocks.
- R10: busy is high from the cycle after an accepted start until the request is complete, and a start pulse while busy has no effect.
- R11: A request runs rep_count frames, with a rep_count of 0 acting as 1. A power-down request ignores rep_count and runs one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run of frames |
| pd_req | input | 1 | Sampled with start: run a shortened power-down frame |
| cpha | input | 1 | Clock phase select, sampled with start |
| half_div | input | 8 | System clocks per sclk half-period, sampled with start |
| rep_count | input | 8 | Frames per request, sampled with start |
| cs_man_n | input | 1 | Manual chip-select level used in phase 1 |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, resting high |
| busy | output | 1 | A request is in progress |
| sample | output | 12 | Last aligned conversion result |
| sample_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench builds the block with its default parameters: 16-bit frames, 12-bit results, 8-clock power-down frames and an 8-bit divider. Because half_div is a port, one build covers divider settings from the single-cycle half period (including 0, which acts as 1) up to several cycles, in both phases. It also reaches both alignment shifts, multi-frame runs with their inter-frame chip-select gaps, and the shortened power-down frame.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sclk_tick.sv
// Half-period timer: pulses tick every div cycles while run is high.
module sclk_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div - DIV_W'(1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: with a divider above one, ticks never come on adjacent cycles
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/rx_shifter.sv
// MSB-first receive shift register.
module rx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clr)      word_d = '0;
        else if (cap) word_d = {word_q[WORD_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;

    // R4: a new frame starts from an empty register
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (word == '0));

endmodule

// File: rtl/result_align.sv
// Phase-dependent right shift that extracts the conversion result.
module result_align #(
    parameter int WORD_W = 16,
    parameter int RES_W  = 12,
    parameter int PAD0   = 2,
    parameter int PAD1   = 3
) (
    input  logic [WORD_W-1:0] word,
    input  logic              phase1,
    output logic [RES_W-1:0]  result
);
    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted = phase1 ? (word >> PAD1) : (word >> PAD0);
        result  = shifted[RES_W-1:0];
    end

endmodule

// File: rtl/adc_spi_sampler.sv
module adc_spi_sampler
    import adc_spi_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int REP_W   = 8,
    parameter int WORD_W  = 16,
    parameter int RES_W   = 12,
    parameter int PD_BITS = 8,
    parameter int PAD0    = 2,
    parameter int PAD1    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pd_req,
    input  logic             cpha,
    input  logic [DIV_W-1:0] half_div,
    input  logic [REP_W-1:0] rep_count,
    input  logic             cs_man_n,
    input  logic             miso,
    output logic             cs_n,
    output logic             sclk,
    output logic             busy,
    output logic [RES_W-1:0] sample,
    output logic             sample_valid
);
    localparam int EDGE_W = $clog2(2 * WORD_W + 1);
    localparam logic [EDGE_W-1:0] LAST_FULL = EDGE_W'(2 * WORD_W);
    localparam logic [EDGE_W-1:0] LAST_PD   = EDGE_W'(2 * PD_BITS);

    typedef struct packed {
        seq_state_e       st;
        logic [DIV_W-1:0] hd;
        logic             cpha;
        logic             pd;
        logic [REP_W-1:0] left;
        logic [EDGE_W-1:0] edges;
        logic             sclk;
        logic             cs;
        logic             valid;
        logic [RES_W-1:0] res;
    } ctl_t;

    ctl_t q, d;
    logic tick, cap, clr;
    logic [WORD_W-1:0] rx_word;
    logic [RES_W-1:0]  aligned;
    logic [EDGE_W-1:0] last_edge;

    sclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .div   (q.hd),
        .tick  (tick)
    );

    rx_shifter #(.WORD_W(WORD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .cap    (cap),
        .bit_in (miso),
        .word   (rx_word)
    );

    result_align #(.WORD_W(WORD_W), .RES_W(RES_W), .PAD0(PAD0), .PAD1(PAD1)) u_align (
        .word   (rx_word),
        .phase1 (q.cpha),
        .result (aligned)
    );

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        cap       = 1'b0;
        clr       = 1'b0;
        last_edge = q.pd ? LAST_PD : LAST_FULL;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_LEAD;
                    d.hd    = (half_div == '0) ? DIV_W'(1) : half_div;
                    d.cpha  = cpha;
                    d.pd    = pd_req;
                    d.left  = (pd_req || rep_count == '0) ? REP_W'(1) : rep_count;
                    d.cs    = 1'b0;
                    d.edges = '0;
                    clr     = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    d.st    = ST_SHIFT;
                    d.sclk  = 1'b0;
                    d.edges = EDGE_W'(1);
                    cap     = !q.cpha;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (q.edges == last_edge) begin
                        d.st    = ST_GAP;
                        d.cs    = 1'b1;
                        d.edges = '0;
                        d.valid = !q.pd;
                        if (!q.pd) d.res = aligned;
                    end else begin
                        d.sclk  = ~q.sclk;
                        d.edges = q.edges + EDGE_W'(1);
                        cap     = ((~q.sclk) == q.cpha);
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.edges == EDGE_W'(1)) begin
                        if (q.left > REP_W'(1)) begin
                            d.left  = q.left - REP_W'(1);
                            d.st    = ST_LEAD;
                            d.cs    = 1'b0;
                            d.edges = '0;
                            clr     = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.edges = q.edges + EDGE_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.hd    <= DIV_W'(1);
            q.left  <= REP_W'(1);
            q.sclk  <= 1'b1;
            q.cs    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.st != ST_IDLE);
    assign sclk         = q.sclk;
    assign cs_n         = (busy ? q.cpha : cpha) ? cs_man_n : q.cs;
    assign sample       = q.res;
    assign sample_valid = q.valid;

    // R7: the result strobe never lasts two cycles
    p_valid_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R2: clock and automatic select rest high when idle
    p_idle_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (q.sclk && q.cs));

    // R9: the inter-frame gap keeps select released and clock high
    p_gap_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> (q.cs && q.sclk));

    // R8: a power-down frame never reports a result
    p_pd_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && q.pd) |=> !sample_valid);

    // R10: a start in mid-frame does not restart the sequence
    p_start_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && start) |=> (q.st != ST_LEAD));

endmodule

// File: tb/adc_spi_sampler_test.sv
module adc_spi_sampler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pd_req = 1'b0;
    logic        cpha = 1'b0;
    logic [7:0]  half_div = 8'd4;
    logic [7:0]  rep_count = 8'd1;
    logic        cs_man_n = 1'b1;
    logic        miso = 1'b0;
    logic        cs_n, sclk, busy, sample_valid;
    logic [11:0] sample;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [15:0] tx_word = '0;
    int bitp = 0;

    // monitor state
    int n_vhigh, n_vrise, n_fall, since, edges_seen, hp_min, hp_max;
    int hi_run, gap_min, frames_seen, falls_at_rise;
    logic pv = 1'b0, ps = 1'b1, ps_cs = 1'b1;
    logic [11:0] last_sample;

    always #10 clk = ~clk;

    adc_spi_sampler uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pd_req(pd_req), .cpha(cpha),
        .half_div(half_div), .rep_count(rep_count), .cs_man_n(cs_man_n), .miso(miso),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .sample(sample), .sample_valid(sample_valid)
    );

    // converter model: new bit on the edge opposite to the capture edge
    always @(posedge sclk) if (!cpha && rst_n) begin
        bitp = (bitp + 1) % 16;
        miso = tx_word[15 - bitp];
    end
    always @(negedge sclk) if (cpha && rst_n) begin
        miso = tx_word[15 - bitp];
        bitp = (bitp + 1) % 16;
    end

    always @(negedge clk) begin
        if (sample_valid) begin n_vhigh++; last_sample = sample; end
        if (sample_valid && !pv) n_vrise++;
        pv = sample_valid;
        if (busy) begin
            since++;
            if (sclk != ps) begin
                if (edges_seen > 0) begin
                    if (since < hp_min) hp_min = since;
                    if (since > hp_max) hp_max = since;
                end
                edges_seen++;
                since = 0;
                if (ps && !sclk && !cs_n) n_fall++;
            end
            if (cs_n) begin
                hi_run++;
                if (!ps_cs) falls_at_rise = n_fall;
            end else begin
                if (ps_cs) begin
                    if (frames_seen > 0 && hi_run < gap_min) gap_min = hi_run;
                    frames_seen++;
                end
                hi_run = 0;
            end
        end
        ps = sclk;
        ps_cs = cs_n;
    end

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input bit ph, input logic [15:0] w, input int div, input int rep,
                       input bit pd, input bit extra);
        n_vhigh = 0; n_vrise = 0; n_fall = 0; since = 0; edges_seen = 0;
        hp_min = 1000; hp_max = 0; hi_run = 0; gap_min = 1000; frames_seen = 0;
        falls_at_rise = -1;
        @(negedge clk);
        cpha = ph; half_div = 8'(div); rep_count = 8'(rep); pd_req = pd;
        cs_man_n = ph ? 1'b0 : 1'b1;
        tx_word = w; bitp = 0; miso = w[15];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        if (extra) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        cs_man_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // {cpha, half_div, word, expected result}
    localparam logic [36:0] VEC [0:7] = '{
        {1'b0, 8'd4, 16'h3FFC, 12'hFFF},
        {1'b0, 8'd1, 16'hABCD, 12'hAF3},
        {1'b1, 8'd2, 16'hABCD, 12'h579},
        {1'b1, 8'd3, 16'h1FF8, 12'h3FF},
        {1'b0, 8'd4, 16'h0004, 12'h001},
        {1'b1, 8'd1, 16'hFFFF, 12'hFFF},
        {1'b0, 8'd5, 16'h0000, 12'h000},
        {1'b1, 8'd2, 16'h5550, 12'hAAA}
    };

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        check(sclk == 1'b1, "R1 sclk in reset", int'(sclk), 1);
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(sample_valid == 1'b0, "R1 valid in reset", int'(sample_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            logic [36:0] e;
            e = VEC[v];
            run(e[36], e[27:12], int'(e[35:28]), 1, 1'b0, 1'b0);
            check(last_sample == e[11:0], e[36] ? "R5 phase1 result" : "R4 phase0 result",
                  int'(last_sample), int'(e[11:0]));
            check(sample == e[11:0], "R7 sample held", int'(sample), int'(e[11:0]));
            check(n_vrise == 1 && n_vhigh == 1, "R7 one-cycle valid", n_vhigh, 1);
            check(n_fall == 16, "R3 falling edges", n_fall, 16);
            check(hp_min == int'(e[35:28]) && hp_max == int'(e[35:28]), "R2 half period",
                  hp_max, int'(e[35:28]));
            check(sclk == 1'b1, "R2 sclk rests high", int'(sclk), 1);
        end

        // R2 divider of zero acts as one
        run(1'b0, 16'h2AA8, 0, 1, 1'b0, 1'b0);
        check(hp_min == 1 && hp_max == 1, "R2 zero divider", hp_max, 1);
        check(last_sample == 12'hAAA, "R4 zero divider result", int'(last_sample), 'hAAA);

        // R11 / R9 repeated frames
        run(1'b0, 16'h1234, 2, 3, 1'b0, 1'b0);
        check(n_vrise == 3, "R11 three frames", n_vrise, 3);
        check(gap_min >= 4, "R9 select gap", gap_min, 4);
        check(last_sample == 12'h48D, "R4 repeat result", int'(last_sample), 'h48D);
        run(1'b1, 16'h1234, 3, 2, 1'b0, 1'b0);
        check(n_vrise == 2, "R11 phase1 two frames", n_vrise, 2);
        check(last_sample == 12'h246, "R5 repeat result", int'(last_sample), 'h246);
        run(1'b0, 16'h0FF0, 1, 0, 1'b0, 1'b0);
        check(n_vrise == 1, "R11 zero count acts as one", n_vrise, 1);

        // R8 power-down frame
        run(1'b0, 16'hFFFF, 2, 1, 1'b1, 1'b0);
        check(n_fall == 8, "R8 eight falls", n_fall, 8);
        check(falls_at_rise == 8, "R8 select released before ninth fall", falls_at_rise, 8);
        check(n_vhigh == 0, "R8 no result", n_vhigh, 0);
        check(sample == 12'h3FC, "R8 sample untouched", int'(sample), 'h3FC);
        run(1'b0, 16'hFFFF, 1, 5, 1'b1, 1'b0);
        check(n_fall == 8, "R11 power-down ignores count", n_fall, 8);

        // R10 start while busy ignored
        run(1'b0, 16'h0800, 3, 1, 1'b0, 1'b1);
        check(n_vrise == 1, "R10 extra start ignored", n_vrise, 1);
        check(busy == 1'b0, "R10 idle afterwards", int'(busy), 0);

        // R6 chip-select source
        @(negedge clk);
        cpha = 1'b1; cs_man_n = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b0, "R6 manual select low", int'(cs_n), 0);
        cs_man_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R6 manual select high", int'(cs_n), 1);
        cpha = 1'b0; cs_man_n = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b1, "R6 manual input ignored in phase0", int'(cs_n), 1);
        cs_man_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule